// File: doc/BRIEF.md
# Quad Recirculating Serial Delay Register

This block holds four independent bit-serial delay lines, each 64 stages deep and one bit wide. Every lane has its own serial input, its own shift enable and its own serial output, and all four run on one common system clock. A lane moves its contents one stage toward its output only in a cycle where its shift enable is high. In every other cycle it holds what it stores.

What enters the first stage of a lane on a shift depends on a recycle control. When recycle is low, the lane takes its external serial input. When recycle is high, the lane takes its own last-stage bit, so the stored word rotates and nothing is lost. One recycle control serves lanes 0 and 1, and a second one serves lanes 2 and 3. Because each serial output is the content of the final stage, the output of one lane can be wired to the input of another to form a longer delay line.

The stored bits have no power-up value. A synchronous clear input, which can be left out by a parameter, zeroes all four lanes so that tests can start from a known state.

Top module: `quad_recirc_shreg`

## Requirements
- R1: While `rst` is high on a clock edge, all four lanes are cleared to zero, so every `ser_out` bit reads 0 in the cycle after the clear.
- R2: A lane whose `shift_en` bit is low in a cycle keeps its contents, and its `ser_out` bit does not change at that edge.
- R3: With its recycle bit low, a shifting lane loads its `ser_in` bit into stage 0. That bit appears on `ser_out` after exactly 64 shifts of that lane, and not after 63.
- R4: With its recycle bit high, a shifting lane loads its own last-stage bit into stage 0, and the lane's `ser_in` bit has no effect on the contents.
- R5: `recycle[0]` governs lanes 0 and 1, and `recycle[1]` governs lanes 2 and 3. Lane index n uses recycle bit n/2.
- R6: After 64 recycled shifts, a lane's contents are back in their original stages, so the next 64 recycled shifts produce the same output bit sequence as the previous 64.
- R7: Shifting one lane of a pair leaves the other lane of that pair unchanged whenever the other lane's enable is low.
- R8: `ser_out` of a lane is the content of its 64th stage. Feeding lane 0's output into lane 1's input therefore gives a 128-shift delay from `ser_in[0]` to `ser_out[1]`.
- R9: A change on a recycle bit in a cycle where neither lane of its pair shifts has no effect on the stored contents.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Common system clock, rising edge |
| rst | input | 1 | Synchronous clear of all stored bits, active high |
| shift_en | input | NUM_PAIRS*2 (4) | Per-lane shift enable, one bit per lane |
| ser_in | input | NUM_PAIRS*2 (4) | Per-lane external serial data input |
| recycle | input | NUM_PAIRS (2) | Recycle select, bit 0 for lanes 0/1, bit 1 for lanes 2/3 |
| ser_out | output | NUM_PAIRS*2 (4) | Per-lane last-stage output |

## Verification
The two functions that meet in one cycle are a shift on one lane of a pair and a hold on its partner, while both lanes read the same recycle bit. A vector table provokes them by firing single enables and mixed enables under every recycle setting. Recycle flips are also placed in cycles with no shift. Each lane is judged at every step against a 64-entry reference queue in the bench. A rotation test compares two successive 64-shift output sequences, and a pair-split test checks that the idle partner's output and later contents did not move.

// File: rtl/qrs_pkg.sv
package qrs_pkg;

    // Lanes that share one recycle select.
    localparam int unsigned LANES_PER_PAIR = 2;

    // Per-lane control sampled in one cycle.
    typedef struct packed {
        logic shift;
        logic din;
        logic recycle;
    } lane_ctl_t;

    // Bit that enters stage 0 on a shift.
    function automatic logic entry_bit(input lane_ctl_t ctl, input logic tail);
        return ctl.recycle ? tail : ctl.din;
    endfunction

endpackage

// File: rtl/qrs_lane.sv
module qrs_lane
    import qrs_pkg::*;
#(
    parameter int unsigned DEPTH    = 64,
    parameter bit          CLEAR_EN = 1'b1
) (
    input  logic      clk,
    input  logic      clr,
    input  lane_ctl_t ctl,
    output logic      tail_out
);

    localparam int unsigned LAST = DEPTH - 1;

    logic [LAST:0] stages;
    logic          new_bit;

    always_comb begin
        new_bit = entry_bit(ctl, stages[LAST]);
    end

    generate
        if (CLEAR_EN) begin : g_clr
            always_ff @(posedge clk) begin
                if (clr) begin
                    stages <= '0;
                end else if (ctl.shift) begin
                    stages <= {stages[LAST-1:0], new_bit};
                end
            end
        end else begin : g_noclr
            always_ff @(posedge clk) begin
                if (ctl.shift) begin
                    stages <= {stages[LAST-1:0], new_bit};
                end
            end
        end
    endgenerate

    assign tail_out = stages[LAST];

endmodule

// File: rtl/qrs_pair.sv
module qrs_pair
    import qrs_pkg::*;
#(
    parameter int unsigned DEPTH    = 64,
    parameter bit          CLEAR_EN = 1'b1
) (
    input  logic                      clk,
    input  logic                      clr,
    input  logic [LANES_PER_PAIR-1:0] shift_en,
    input  logic [LANES_PER_PAIR-1:0] ser_in,
    input  logic                      recycle,
    output logic [LANES_PER_PAIR-1:0] ser_out
);

    lane_ctl_t ctl [LANES_PER_PAIR];

    generate
        for (genvar k = 0; k < LANES_PER_PAIR; k++) begin : g_lane
            always_comb begin
                ctl[k].shift   = shift_en[k];
                ctl[k].din     = ser_in[k];
                ctl[k].recycle = recycle;
            end

            qrs_lane #(
                .DEPTH    (DEPTH),
                .CLEAR_EN (CLEAR_EN)
            ) lane_i (
                .clk      (clk),
                .clr      (clr),
                .ctl      (ctl[k]),
                .tail_out (ser_out[k])
            );
        end
    endgenerate

endmodule

// File: rtl/quad_recirc_shreg.sv
module quad_recirc_shreg
    import qrs_pkg::*;
#(
    parameter int unsigned DEPTH     = 64,
    parameter int unsigned NUM_PAIRS = 2,
    parameter bit          CLEAR_EN  = 1'b1,
    localparam int unsigned NUM_LANES = NUM_PAIRS * LANES_PER_PAIR
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic [NUM_LANES-1:0] shift_en,
    input  logic [NUM_LANES-1:0] ser_in,
    input  logic [NUM_PAIRS-1:0] recycle,
    output logic [NUM_LANES-1:0] ser_out
);

    generate
        for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_pair
            localparam int unsigned BASE = p * LANES_PER_PAIR;

            qrs_pair #(
                .DEPTH    (DEPTH),
                .CLEAR_EN (CLEAR_EN)
            ) pair_i (
                .clk      (clk),
                .clr      (rst),
                .shift_en (shift_en[BASE +: LANES_PER_PAIR]),
                .ser_in   (ser_in[BASE +: LANES_PER_PAIR]),
                .recycle  (recycle[p]),
                .ser_out  (ser_out[BASE +: LANES_PER_PAIR])
            );
        end
    endgenerate

endmodule

// File: rtl/qrs_checker.sv
module qrs_checker #(
    parameter int unsigned NUM_LANES = 4,
    parameter int unsigned NUM_PAIRS = 2,
    parameter bit          CLEAR_EN  = 1'b1
) (
    input logic                 clk,
    input logic                 rst,
    input logic [NUM_LANES-1:0] shift_en,
    input logic [NUM_LANES-1:0] ser_in,
    input logic [NUM_PAIRS-1:0] recycle,
    input logic [NUM_LANES-1:0] ser_out
);

    localparam int unsigned PER_PAIR = NUM_LANES / NUM_PAIRS;

    generate
        for (genvar l = 0; l < NUM_LANES; l++) begin : g_lane_chk
            localparam int unsigned PARTNER = l ^ 1;
            localparam int unsigned PIDX    = l / PER_PAIR;

            // R2: an idle lane keeps its output
            p_hold_r2 : assert property (@(posedge clk) disable iff (rst)
                !shift_en[l] |=> $stable(ser_out[l]));

            // R7: partner shifting alone does not disturb this lane
            p_partner_r7 : assert property (@(posedge clk) disable iff (rst)
                (shift_en[PARTNER] && !shift_en[l]) |=> $stable(ser_out[l]));

            // R9: recycle flip without a shift in the pair has no effect
            p_recycle_idle_r9 : assert property (@(posedge clk) disable iff (rst)
                ((recycle[PIDX] != $past(recycle[PIDX])) && !shift_en[l]
                 && !shift_en[PARTNER]) |=> $stable(ser_out[l]));
        end

        if (CLEAR_EN) begin : g_clr_chk
            // R1: the cycle after a clear sees all outputs low
            p_clear_r1 : assert property (@(posedge clk) disable iff (rst)
                $fell(rst) |-> (ser_out == '0));
        end
    endgenerate

endmodule

bind quad_recirc_shreg qrs_checker #(
    .NUM_LANES (NUM_LANES),
    .NUM_PAIRS (NUM_PAIRS),
    .CLEAR_EN  (CLEAR_EN)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .shift_en (shift_en),
    .ser_in   (ser_in),
    .recycle  (recycle),
    .ser_out  (ser_out)
);

// File: tb/quad_recirc_shreg_tb.sv
module quad_recirc_shreg_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int LANES      = 4;
    localparam int DEPTH      = 64;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [LANES-1:0] shift_en = '0;
    logic [LANES-1:0] ser_in   = '0;
    logic [1:0]       recycle  = '0;
    logic [LANES-1:0] ser_out;

    int checks = 0;
    int errors = 0;
    logic [DEPTH-1:0] mdl [LANES];

    // {shift_en[3:0], ser_in[3:0], recycle[1:0]}
    localparam logic [9:0] VEC [16] = '{
        10'b1111_1010_00, 10'b0001_1111_01, 10'b0010_0000_10, 10'b1100_0101_11,
        10'b0001_1001_00, 10'b0000_1111_11, 10'b0100_1100_01, 10'b1000_0011_10,
        10'b0011_0110_10, 10'b1111_0001_11, 10'b0000_0000_01, 10'b1010_1110_00,
        10'b0101_0111_01, 10'b1111_1111_10, 10'b0010_1000_00, 10'b1001_0100_11
    };

    quad_recirc_shreg dut_i (
        .clk      (clk),
        .rst      (rst),
        .shift_en (shift_en),
        .ser_in   (ser_in),
        .recycle  (recycle),
        .ser_out  (ser_out)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check_bit(input string req, input int lane, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s lane %0d: actual=%b expected=%b", req, lane, act, exp);
        end
    endtask

    task automatic check_all(input string req);
        for (int l = 0; l < LANES; l++) check_bit(req, l, ser_out[l], mdl[l][DEPTH-1]);
    endtask

    // One shift cycle: drive at negedge, update model at edge, sample at next negedge.
    task automatic step(input logic [3:0] en, input logic [3:0] din, input logic [1:0] rec,
                        input string req);
        @(negedge clk);
        shift_en = en; ser_in = din; recycle = rec;
        @(posedge clk);
        for (int l = 0; l < LANES; l++) begin
            if (en[l]) begin
                logic nb;
                nb = rec[l/2] ? mdl[l][DEPTH-1] : din[l];
                mdl[l] = {mdl[l][DEPTH-2:0], nb};
            end
        end
        @(negedge clk);
        check_all(req);
        shift_en = '0;
    endtask

    task automatic do_clear();
        @(negedge clk);
        rst = 1'b1;
        @(posedge clk);
        for (int l = 0; l < LANES; l++) mdl[l] = '0;
        @(negedge clk);
        rst = 1'b0;
        check_all("R1");
    endtask

    function automatic logic pat(input int k, input int l);
        return logic'(((k * 5 + l * 3) % 7) < 3);
    endfunction

    initial begin : watchdog
        #(CLK_PERIOD * 150000);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin : main
        logic [DEPTH-1:0] seq_a [LANES];
        logic [DEPTH-1:0] seq_b [LANES];

        // R1: reset state
        repeat (2) @(posedge clk);
        for (int l = 0; l < LANES; l++) mdl[l] = '0;
        @(negedge clk);
        rst = 1'b0;
        check_all("R1");

        // Table walk, varied data per pass (R2, R4, R5, R7 mixed)
        for (int pass = 0; pass < 24; pass++) begin
            for (int i = 0; i < 16; i++) begin
                logic [9:0] v;
                v = VEC[i];
                step(v[9:6], v[5:2] ^ 4'(pass), v[1:0], "R2/R7 table");
            end
        end

        // R3: single one into lane 2, visible after 64 shifts, not 63
        do_clear();
        step(4'b0100, 4'b0100, 2'b00, "R3");
        for (int k = 1; k < DEPTH - 1; k++) step(4'b0100, 4'b0000, 2'b00, "R3");
        check_bit("R3 not after 63", 2, ser_out[2], 1'b0);
        step(4'b0100, 4'b0000, 2'b00, "R3");
        check_bit("R3 after 64", 2, ser_out[2], 1'b1);

        // R4: recycle high, ser_in held at one is ignored
        do_clear();
        for (int k = 0; k < DEPTH + 4; k++) step(4'b1111, 4'b1111, 2'b11, "R4");
        for (int l = 0; l < LANES; l++) check_bit("R4 ignored", l, ser_out[l], 1'b0);

        // R5: recycle[0] covers lanes 0/1, recycle[1]=0 lets lanes 2/3 load
        do_clear();
        for (int k = 0; k < DEPTH; k++) step(4'b1111, 4'b1111, 2'b01, "R5");
        check_bit("R5 lane0 recycled", 0, ser_out[0], 1'b0);
        check_bit("R5 lane1 recycled", 1, ser_out[1], 1'b0);
        check_bit("R5 lane2 loaded", 2, ser_out[2], 1'b1);
        check_bit("R5 lane3 loaded", 3, ser_out[3], 1'b1);

        // R6: load distinct patterns, then two rotations must match
        for (int k = 0; k < DEPTH; k++)
            step(4'b1111, {pat(k,3), pat(k,2), pat(k,1), pat(k,0)}, 2'b00, "R6 load");
        for (int k = 0; k < DEPTH; k++) begin
            step(4'b1111, 4'b1010, 2'b11, "R6");
            for (int l = 0; l < LANES; l++) seq_a[l][k] = ser_out[l];
        end
        for (int k = 0; k < DEPTH; k++) begin
            step(4'b1111, 4'b0101, 2'b11, "R6");
            for (int l = 0; l < LANES; l++) seq_b[l][k] = ser_out[l];
        end
        for (int l = 0; l < LANES; l++) begin
            checks++;
            if (seq_a[l] !== seq_b[l]) begin
                errors++;
                $display("FAIL R6 lane %0d: actual=%h expected=%h", l, seq_b[l], seq_a[l]);
            end
        end

        // R7: shift lane 0 only, lane 1 must keep its word
        for (int k = 0; k < 20; k++) step(4'b0001, 4'(k), 2'b00, "R7");
        for (int k = 0; k < DEPTH; k++) step(4'b0010, 4'b0000, 2'b11, "R7 partner readback");

        // R9: recycle toggles with no shift
        for (int k = 0; k < 6; k++) begin
            @(negedge clk);
            recycle = 2'(k);
            ser_in  = 4'hF;
            @(negedge clk);
            check_all("R9");
        end
        for (int k = 0; k < DEPTH; k++) step(4'b1111, 4'b0000, 2'b11, "R9 readback");

        // R8: cascade lane 0 into lane 1, 128-shift delay
        do_clear();
        for (int k = 0; k < 2 * DEPTH; k++) begin
            logic b0;
            b0 = (k == 0);
            step(4'b0011, {2'b00, ser_out[0], b0}, 2'b00, "R8");
            if (k == 2 * DEPTH - 2) check_bit("R8 not after 127", 1, ser_out[1], 1'b0);
        end
        check_bit("R8 after 128", 1, ser_out[1], 1'b1);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule